// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a compact 32-bit processor core. It runs every instruction as a series of steps on a single shared datapath. An instruction passes through up to five steps: fetch, decode, execute, memory and write-back. Each class of instruction leaves that sequence at its own point, so instruction lengths range from two to five clock cycles. A set of holding registers carries partial results from one step to the next:

- the instruction word,
- the incremented PC,
- the two source operands,
- the extended immediate,
- the ALU result,
- the loaded data word.

The core holds its own instruction and data memories as small internal arrays. The instruction array is filled through a write port, normally while reset is held. After reset is released, execution starts at address zero. The core raises a one-cycle `retire` pulse in the final step of each instruction. In that same cycle it shows the current PC, the register write-back and any data store on observation ports, so a bench can follow it without looking inside.

Top module: `mc_core`

## Requirements
- R1: While synchronous active-low reset is applied, PC reads 0, `retire`, `wb_en` and `st_en` are low, and all registers and data words read 0. After release, the first fetch is from byte address 0.
- R2: PC only changes at the clock edge that ends a retiring cycle. For every non-branch instruction it then becomes PC + 4. The instruction word index is PC[IAW+1:2].
- R3: Register-register ops use opcode 0x00 and take 4 cycles. The funct field selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. The result goes to register rd in the final cycle.
- R4: Add-immediate uses opcode 0x08 and takes 4 cycles. It writes rs plus the sign-extended 16-bit immediate to register rt.
- R5: Load word uses opcode 0x23 and takes 5 cycles. It reads the data word at rs + sign-extended immediate (word index = address[DAW+1:2]) and writes it to rt.
- R6: Store word uses opcode 0x2B and takes 4 cycles. It writes rt to the data word at rs + sign-extended immediate. `st_en` is high only in its final cycle, and it writes no register.
- R7: Branch-if-zero (0x04) and branch-if-nonzero (0x05) test rs against zero and take 3 cycles. A taken branch sets PC to PC + 4 + sign-extended immediate; otherwise PC becomes PC + 4.
- R8: Register 0 always reads as zero. A write-back addressed to it appears on the observation port but has no effect.
- R9: Any other opcode acts as a no-op: it retires after 2 cycles (fetch, decode) with no register or memory effect.
- R10: `retire` is high for exactly one cycle per instruction, in its final step, and never in two consecutive cycles.
- R11: The instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Instruction array write enable |
| load_addr | input | IAW | Instruction array word index |
| load_data | input | 32 | Instruction word to write |
| retire | output | 1 | High in the final cycle of each instruction |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | Register write-back happening this cycle |
| wb_idx | output | 5 | Destination register of the write-back |
| wb_data | output | 32 | Value written back |
| st_en | output | 1 | Data store happening this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
Two things coincide in the retiring cycle. The first is the write-back or store of one instruction together with the PC update. The second follows from it: the next instruction reads, in its decode step, a register or data word written only one or two cycles earlier.

The program provokes both. It places a store directly before a load from the same address, and a load directly before an add that uses the loaded value. It also checks a taken and a not-taken branch against a register produced by a set-less-than. A behavioural reference model decides, every cycle, whether `retire`, the PC, the write-back and the store ports should be active and with which values.

// File: rtl/mc_pkg.sv
// Shared types and encodings for the multi-cycle core.
// Assumes 32-bit words and a 32-entry register file.
package mc_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;

    typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WRITE} step_e;
    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
    typedef enum logic [2:0] {CL_REG, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_NOP} class_e;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BRZ   = 6'h04;
    localparam logic [5:0] OPC_BRNZ  = 6'h05;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // Map an opcode onto the step sequence it follows
    function automatic class_e classify(input logic [5:0] opc);
        case (opc)
            OPC_REG:           return CL_REG;
            OPC_ADDI:          return CL_IMM;
            OPC_LOAD:          return CL_LOAD;
            OPC_STORE:         return CL_STORE;
            OPC_BRZ, OPC_BRNZ: return CL_BRANCH;
            default:           return CL_NOP;
        endcase
    endfunction

    // Map a funct code onto an ALU operation (unknown codes add)
    function automatic alu_op_e funct_op(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction
endpackage

// File: rtl/mc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 reads as zero and ignores writes. Synchronous active-low reset clears all entries.
module mc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise write any entry except zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mc_alu.sv
// Combinational ALU: add, subtract, and, or, signed set-less-than.
// Assumes operands have already been chosen by the caller.
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Select the result for the requested operation
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mc_ctrl.sv
// Step sequencer: walks fetch, decode, execute, memory, write-back and leaves early per class.
// Assumes the class input is valid from the decode step onward.
module mc_ctrl
    import mc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  class_e cls,
    output step_e  step,
    output logic   retire
);
    step_e nxt;

    // Choose the next step and flag the final step of each instruction
    always_comb begin
        nxt    = step;
        retire = 1'b0;
        case (step)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                if (cls == CL_NOP) begin
                    nxt    = ST_FETCH;
                    retire = 1'b1;
                end else begin
                    nxt = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (cls == CL_BRANCH) begin
                    nxt    = ST_FETCH;
                    retire = 1'b1;
                end else if (cls == CL_LOAD || cls == CL_STORE) begin
                    nxt = ST_MEM;
                end else begin
                    nxt = ST_WRITE;
                end
            end
            ST_MEM: begin
                if (cls == CL_STORE) begin
                    nxt    = ST_FETCH;
                    retire = 1'b1;
                end else begin
                    nxt = ST_WRITE;
                end
            end
            ST_WRITE: begin
                nxt    = ST_FETCH;
                retire = 1'b1;
            end
            default: nxt = ST_FETCH;
        endcase
    end

    // Advance the step register
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_FETCH;
        else        step <= nxt;
    end
endmodule

// File: rtl/mc_core.sv
// Multi-cycle core top: holding registers, internal instruction and data arrays, observation ports.
// Assumes word-aligned addresses; the instruction array is written through the load port.
module mc_core
    import mc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_we,
    input  logic [IAW-1:0]  load_addr,
    input  logic [XLEN-1:0] load_data,
    output logic            retire,
    output logic [XLEN-1:0] pc_o,
    output logic            wb_en,
    output logic [RAW-1:0]  wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic            st_en,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc, ir, npc, a_q, b_q, imm_q, alu_q, lmd_q;
    logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, pc_next;
    step_e           step;
    class_e          cls;
    alu_op_e         aop;
    logic            cond;

    wire [5:0]     f_opc = ir[31:26];
    wire [RAW-1:0] f_rs  = ir[25:21];
    wire [RAW-1:0] f_rt  = ir[20:16];
    wire [RAW-1:0] f_rd  = ir[15:11];
    wire [5:0]     f_fn  = ir[5:0];

    assign cls = classify(f_opc);

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls    (cls),
        .step   (step),
        .retire (retire)
    );

    mc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wb_en),
        .waddr   (wb_idx),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // Pick ALU operation and operands for the execute step
    always_comb begin
        aop   = (cls == CL_REG) ? funct_op(f_fn) : ALU_ADD;
        alu_a = (cls == CL_BRANCH) ? npc : a_q;
        alu_b = (cls == CL_REG) ? b_q : imm_q;
    end

    mc_alu #(.W(XLEN)) u_alu (
        .op (aop),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Branch condition and the PC value taken at retirement
    always_comb begin
        cond    = (f_opc == OPC_BRZ) ? (a_q == '0) : (a_q != '0);
        pc_next = (step == ST_EXEC && cls == CL_BRANCH && cond) ? alu_y : npc;
    end

    // Holding registers loaded step by step, PC updated at retirement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; ir <= '0; npc <= '0; a_q <= '0;
            b_q <= '0; imm_q <= '0; alu_q <= '0; lmd_q <= '0;
        end else begin
            case (step)
                ST_FETCH: begin
                    ir  <= imem[pc[IAW+1:2]];
                    npc <= pc + XLEN'(4);
                end
                ST_DECODE: begin
                    a_q   <= rf_a;
                    b_q   <= rf_b;
                    imm_q <= {{(XLEN-16){ir[15]}}, ir[15:0]};
                end
                ST_EXEC: alu_q <= alu_y;
                ST_MEM:  if (cls == CL_LOAD) lmd_q <= dmem[alu_q[DAW+1:2]];
                default: ;
            endcase
            if (retire) pc <= pc_next;
        end
    end

    // Instruction array write port
    always_ff @(posedge clk) begin
        if (load_we) imem[load_addr] <= load_data;
    end

    // Data array: cleared on reset, written by stores
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
        end else if (st_en) begin
            dmem[alu_q[DAW+1:2]] <= b_q;
        end
    end

    assign pc_o    = pc;
    assign wb_en   = (step == ST_WRITE);
    assign wb_idx  = (cls == CL_REG) ? f_rd : f_rt;
    assign wb_data = (cls == CL_LOAD) ? lmd_q : alu_q;
    assign st_en   = (step == ST_MEM) && (cls == CL_STORE);
    assign st_addr = alu_q;
    assign st_data = b_q;
endmodule

// File: rtl/mc_core_chk.sv
// Port-level checker for mc_core, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module mc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        retire,
    input logic [31:0] pc_o,
    input logic        wb_en,
    input logic        st_en
);
    a_r2_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(pc_o));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    a_r6_store_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> retire);

    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> !wb_en);

    a_r3_wb_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> retire);
endmodule

bind mc_core mc_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .retire (retire),
    .pc_o   (pc_o),
    .wb_en  (wb_en),
    .st_en  (st_en)
);

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
// Bench: behavioural instruction-level model compared with the core's ports on every clock.
module tb_mc_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_we;
    logic [5:0]  load_addr;
    logic [31:0] load_data;
    logic        retire, wb_en, st_en;
    logic [31:0] pc_o, wb_data, st_addr, st_data;
    logic [4:0]  wb_idx;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] prog [64];
    logic [31:0] mreg [32];
    logic [31:0] mdm  [64];
    logic [31:0] mpc;
    logic [31:0] seen_r11;

    always #2 clk = ~clk;

    mc_core dut (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .retire(retire), .pc_o(pc_o), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr),
        .st_data(st_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rt, input int rs, input int imm);
        return {opc, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic string tag_of(input logic [5:0] opc);
        case (opc)
            6'h00: return "R3";
            6'h08: return "R4";
            6'h23: return "R5";
            6'h2B: return "R6";
            6'h04, 6'h05: return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic int len_of(input logic [5:0] opc);
        case (opc)
            6'h00, 6'h08, 6'h2B: return 4;
            6'h23: return 5;
            6'h04, 6'h05: return 3;
            default: return 2;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int k;
        int len;
        logic [31:0] iw, rsv, rtv, simm, res, addr;
        logic [5:0] opc;
        string tg;

        rst_n = 1'b0; load_we = 1'b0; load_addr = '0; load_data = '0;
        seen_r11 = 32'hdead_beef;
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(6'h08, 1, 0, 5);
        prog[1]  = enc_i(6'h08, 2, 0, -3);
        prog[2]  = enc_r(6'h20, 3, 1, 2);
        prog[3]  = enc_r(6'h22, 4, 2, 1);
        prog[4]  = enc_r(6'h24, 5, 1, 2);
        prog[5]  = enc_r(6'h25, 6, 1, 2);
        prog[6]  = enc_r(6'h2A, 7, 2, 1);
        prog[7]  = enc_r(6'h2A, 8, 1, 2);
        prog[8]  = enc_i(6'h2B, 3, 0, 8);
        prog[9]  = enc_i(6'h23, 9, 0, 8);
        prog[10] = enc_r(6'h20, 10, 9, 9);
        prog[11] = enc_i(6'h08, 0, 0, 7);
        prog[12] = enc_r(6'h20, 11, 0, 1);
        prog[13] = enc_i(6'h04, 0, 8, 8);
        prog[14] = enc_i(6'h08, 12, 0, 1);
        prog[15] = enc_i(6'h08, 12, 0, 2);
        prog[16] = enc_i(6'h05, 0, 8, 8);
        prog[17] = 32'hFC00_0000;
        prog[18] = enc_i(6'h08, 13, 0, 12);
        prog[19] = enc_i(6'h23, 14, 13, -4);
        prog[20] = enc_i(6'h2B, 4, 13, 0);
        prog[21] = enc_i(6'h23, 15, 0, 12);
        prog[22] = enc_r(6'h20, 16, 15, 14);
        prog[23] = enc_i(6'h04, 0, 0, -4);

        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < 64; i++) mdm[i] = '0;
        mpc = '0;

        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = 6'(i); load_data = prog[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        #1;
        chk(retire === 1'b0, "R1", "retire in reset", {31'd0, retire}, 32'd0);
        chk(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(wb_en === 1'b0, "R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
        chk(st_en === 1'b0, "R1", "st_en in reset", {31'd0, st_en}, 32'd0);

        @(negedge clk);
        rst_n = 1'b1;
        k = 0; len = 0; iw = '0;
        for (int cyc = 0; cyc < 150; cyc++) begin
            #1;
            if (k == 0) begin
                iw  = prog[mpc[7:2]];
                len = len_of(iw[31:26]);
                k   = 1;
            end
            opc = iw[31:26];
            tg  = tag_of(opc);
            chk(retire === (k == len), "R10", "retire", {31'd0, retire}, {31'd0, (k == len)});
            chk(pc_o === mpc, "R2", "pc", pc_o, mpc);
            if (k == len) begin
                rsv  = mreg[iw[25:21]];
                rtv  = mreg[iw[20:16]];
                simm = {{16{iw[15]}}, iw[15:0]};
                res  = '0;
                if (opc == 6'h00) begin
                    case (iw[5:0])
                        6'h20: res = rsv + rtv;
                        6'h22: res = rsv - rtv;
                        6'h24: res = rsv & rtv;
                        6'h25: res = rsv | rtv;
                        default: res = ($signed(rsv) < $signed(rtv)) ? 32'd1 : 32'd0;
                    endcase
                end else if (opc == 6'h08) begin
                    res = rsv + simm;
                end else if (opc == 6'h23) begin
                    addr = rsv + simm;
                    res  = mdm[addr[7:2]];
                end
                if (opc == 6'h00 || opc == 6'h08 || opc == 6'h23) begin
                    int dst;
                    dst = (opc == 6'h00) ? int'(iw[15:11]) : int'(iw[20:16]);
                    chk(wb_en === 1'b1, tg, "wb_en", {31'd0, wb_en}, 32'd1);
                    chk(wb_idx === 5'(dst), "R11", "wb_idx", {27'd0, wb_idx}, dst);
                    chk(wb_data === res, tg, "wb_data", wb_data, res);
                    if (dst == 11) seen_r11 = wb_data;
                    if (dst != 0) mreg[dst] = res;
                end else begin
                    chk(wb_en === 1'b0, tg, "no wb", {31'd0, wb_en}, 32'd0);
                end
                if (opc == 6'h2B) begin
                    addr = rsv + simm;
                    chk(st_en === 1'b1, "R6", "st_en", {31'd0, st_en}, 32'd1);
                    chk(st_addr === addr, "R6", "st_addr", st_addr, addr);
                    chk(st_data === rtv, "R6", "st_data", st_data, rtv);
                    mdm[addr[7:2]] = rtv;
                end else begin
                    chk(st_en === 1'b0, tg, "no store", {31'd0, st_en}, 32'd0);
                end
                if ((opc == 6'h04 && rsv == 0) || (opc == 6'h05 && rsv != 0))
                    mpc = mpc + 32'd4 + simm;
                else
                    mpc = mpc + 32'd4;
                k = 0;
            end else begin
                chk(wb_en === 1'b0, tg, "wb_en early", {31'd0, wb_en}, 32'd0);
                chk(st_en === 1'b0, tg, "st_en early", {31'd0, st_en}, 32'd0);
                k++;
            end
            @(negedge clk);
        end
        // R8: r11 = r0 + r1 after an attempted write of 7 to r0
        chk(seen_r11 === 32'd5, "R8", "r0 reads zero", seen_r11, 32'd5);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule